// File: doc/BRIEF.md
# Stepped Front-End Gain Controller with Hysteresis

This block controls the gain of a tuner front end in discrete steps. Each update tick it reads a measured signal level in dBµV, referred to the antenna. It then moves one of two indices by a single step. The first is an RF attenuator index, where each step is 3 dB more attenuation. The second is an IF gain-cut index, where each step is 6 dB less IF gain from a +18 dB maximum. A band select picks the FM or AM set of thresholds and step limits. A change of band returns both indices to their starting point.

The two loops form a cascade. The RF loop compares the raw level against a threshold that rises by one step size for every step already taken. The IF loop acts only on ticks where the RF loop leaves its index alone. It works on the level left after the current RF attenuation, which is the level minus 3 dB for every RF step. Each loop steps back only after the level has dropped one hysteresis width below the threshold of the step below. This stops the indices from chattering at a boundary. The level detector and the analog attenuators are outside this block and appear only as the index outputs.

Top module: `agc_step_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `rf_idx` and `if_idx` are both 0, meaning no RF attenuation and +18 dB IF gain.
- R2: On a tick with no band change, the RF index k increments when `level` > T + 3·k and k is below its limit. T is 75 for FM (`band_sel`=0) and 80 for AM (`band_sel`=1). A level equal to T + 3·k does not step.
- R3: On such a tick, when k > 0 and `level` < T + 3·(k−1) − 3, the RF index decrements. Between that lower bound and the upper threshold, the RF index holds.
- R4: The RF index saturates at 22 in FM and at 21 in AM, and never goes below 0.
- R5: The IF index j moves only on ticks where the RF index holds. It uses e = `level` − 3·k. It increments when e > S + 6·j and decrements when j > 0 and e < S + 6·(j−1) − 6. S is 40 for FM and 45 for AM. The IF gain is 18 − 6·j dB.
- R6: The IF index saturates at 3 in FM (0 dB) and at 5 in AM (−12 dB).
- R7: Each clock, at most one index changes, and it changes by at most one step. Without `tick`, both indices hold.
- R8: When `band_sel` differs from the value seen at the previous clock, both indices return to 0 at that clock, whatever `tick` and `level` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| band_sel | input | 1 | 0 = FM, 1 = AM |
| tick | input | 1 | Update strobe, one cycle per update |
| level | input | 8 | Measured level in dBµV, unsigned |
| rf_idx | output | 5 | RF attenuation step count, 3 dB per step |
| if_idx | output | 3 | IF gain-cut step count, 6 dB per step |

## Verification
The bench probes each threshold at and one above its value. An off-by-one compare would step at the threshold itself. It holds the level inside each hysteresis window, where a design missing the hysteresis would step back too soon. It drives a large level long enough to reach both limits in each band. A design with a wrong per-band limit, or with a free-running IF loop, would show the wrong index at the saturation check. The check taken right after RF saturation shows whether the IF loop was waiting for the RF loop. Band changes are made during a tick at a high level, where a design that favoured the tick over the reset would leave a nonzero index.

// File: rtl/agc_pkg.sv
`timescale 1ns/1ps
package agc_pkg;
    typedef enum logic {
        BAND_FM = 1'b0,
        BAND_AM = 1'b1
    } band_e;
endpackage

// File: rtl/agc_band_cfg.sv
`timescale 1ns/1ps
// Per-band thresholds and index limits.
module agc_band_cfg
    import agc_pkg::*;
#(
    parameter int MW        = 11,
    parameter int RF_W      = 5,
    parameter int IF_W      = 3,
    parameter int FM_RF_THR = 75,
    parameter int AM_RF_THR = 80,
    parameter int FM_IF_THR = 40,
    parameter int AM_IF_THR = 45,
    parameter int FM_RF_MAX = 22,
    parameter int AM_RF_MAX = 21,
    parameter int FM_IF_MAX = 3,
    parameter int AM_IF_MAX = 5
) (
    input  band_e                  band,
    output logic signed [MW-1:0]   rf_thr,
    output logic signed [MW-1:0]   if_thr,
    output logic [RF_W-1:0]        rf_max,
    output logic [IF_W-1:0]        if_max
);
    always_comb begin
        if (band == BAND_AM) begin
            rf_thr = MW'(AM_RF_THR);
            if_thr = MW'(AM_IF_THR);
            rf_max = RF_W'(AM_RF_MAX);
            if_max = IF_W'(AM_IF_MAX);
        end else begin
            rf_thr = MW'(FM_RF_THR);
            if_thr = MW'(FM_IF_THR);
            rf_max = RF_W'(FM_RF_MAX);
            if_max = IF_W'(FM_IF_MAX);
        end
    end
endmodule

// File: rtl/agc_step_loop.sv
`timescale 1ns/1ps
// One stepped loop: upper threshold grows with the index, the lower one
// sits a hysteresis width below the threshold of the step beneath.
module agc_step_loop #(
    parameter int MW    = 11,
    parameter int IDX_W = 5,
    parameter int STEP  = 3,
    parameter int HYS   = 3
) (
    input  logic signed [MW-1:0] metric,
    input  logic signed [MW-1:0] base,
    input  logic [IDX_W-1:0]     idx,
    input  logic [IDX_W-1:0]     max_idx,
    output logic                 up_req,
    output logic                 dn_req
);
    localparam logic signed [MW-1:0] STEP_S = MW'(STEP);
    localparam logic signed [MW-1:0] HYS_S  = MW'(HYS);

    logic signed [MW-1:0] idx_s;
    logic signed [MW-1:0] upper;
    logic signed [MW-1:0] lower;

    always_comb begin
        idx_s  = MW'(idx);
        upper  = base + STEP_S * idx_s;
        lower  = upper - STEP_S - HYS_S;
        up_req = (idx < max_idx) && (metric > upper);
        dn_req = (idx != '0) && (metric < lower);
    end
endmodule

// File: rtl/agc_step_ctrl.sv
`timescale 1ns/1ps
// Cascaded RF/IF stepped gain controller.
module agc_step_ctrl
    import agc_pkg::*;
#(
    parameter int LVL_W       = 8,
    parameter int RF_W        = 5,
    parameter int IF_W        = 3,
    parameter int RF_STEP_DB  = 3,
    parameter int RF_HYS_DB   = 3,
    parameter int IF_STEP_DB  = 6,
    parameter int IF_HYS_DB   = 6,
    parameter int FM_RF_THR   = 75,
    parameter int AM_RF_THR   = 80,
    parameter int FM_IF_THR   = 40,
    parameter int AM_IF_THR   = 45,
    parameter int FM_RF_MAX   = 22,
    parameter int AM_RF_MAX   = 21,
    parameter int FM_IF_MAX   = 3,
    parameter int AM_IF_MAX   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             band_sel,
    input  logic             tick,
    input  logic [LVL_W-1:0] level,
    output logic [RF_W-1:0]  rf_idx,
    output logic [IF_W-1:0]  if_idx
);
    localparam int MW = LVL_W + 3;
    localparam logic signed [MW-1:0] RF_STEP_S = MW'(RF_STEP_DB);

    typedef struct packed {
        band_e           band;
        logic [RF_W-1:0] rf;
        logic [IF_W-1:0] ifc;
    } agc_state_t;

    agc_state_t st_d, st_q;

    band_e                band_in;
    logic signed [MW-1:0] rf_thr, if_thr;
    logic [RF_W-1:0]      rf_max;
    logic [IF_W-1:0]      if_max;
    logic signed [MW-1:0] lvl_s, eff_s;
    logic                 rf_up, rf_dn, if_up, if_dn;

    assign band_in = band_e'(band_sel);

    agc_band_cfg #(
        .MW(MW), .RF_W(RF_W), .IF_W(IF_W),
        .FM_RF_THR(FM_RF_THR), .AM_RF_THR(AM_RF_THR),
        .FM_IF_THR(FM_IF_THR), .AM_IF_THR(AM_IF_THR),
        .FM_RF_MAX(FM_RF_MAX), .AM_RF_MAX(AM_RF_MAX),
        .FM_IF_MAX(FM_IF_MAX), .AM_IF_MAX(AM_IF_MAX)
    ) u_cfg (
        .band   (st_q.band),
        .rf_thr (rf_thr),
        .if_thr (if_thr),
        .rf_max (rf_max),
        .if_max (if_max)
    );

    // Level after the present RF attenuation feeds the IF loop.
    always_comb begin
        lvl_s = MW'(level);
        eff_s = lvl_s - RF_STEP_S * MW'(st_q.rf);
    end

    agc_step_loop #(
        .MW(MW), .IDX_W(RF_W), .STEP(RF_STEP_DB), .HYS(RF_HYS_DB)
    ) u_rf_loop (
        .metric  (lvl_s),
        .base    (rf_thr),
        .idx     (st_q.rf),
        .max_idx (rf_max),
        .up_req  (rf_up),
        .dn_req  (rf_dn)
    );

    agc_step_loop #(
        .MW(MW), .IDX_W(IF_W), .STEP(IF_STEP_DB), .HYS(IF_HYS_DB)
    ) u_if_loop (
        .metric  (eff_s),
        .base    (if_thr),
        .idx     (st_q.ifc),
        .max_idx (if_max),
        .up_req  (if_up),
        .dn_req  (if_dn)
    );

    always_comb begin
        st_d      = st_q;
        st_d.band = band_in;
        if (band_in != st_q.band) begin
            st_d.rf  = '0;
            st_d.ifc = '0;
        end else if (tick) begin
            if (rf_up)      st_d.rf  = st_q.rf + RF_W'(1);
            else if (rf_dn) st_d.rf  = st_q.rf - RF_W'(1);
            else if (if_up) st_d.ifc = st_q.ifc + IF_W'(1);
            else if (if_dn) st_d.ifc = st_q.ifc - IF_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.band <= BAND_FM;
            st_q.rf   <= '0;
            st_q.ifc  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rf_idx = st_q.rf;
    assign if_idx = st_q.ifc;
endmodule

// File: rtl/agc_step_ctrl_chk.sv
`timescale 1ns/1ps
module agc_step_ctrl_chk #(
    parameter int RF_W      = 5,
    parameter int IF_W      = 3,
    parameter int FM_RF_MAX = 22,
    parameter int AM_RF_MAX = 21,
    parameter int FM_IF_MAX = 3,
    parameter int AM_IF_MAX = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            band_sel,
    input logic            band_q,
    input logic            tick,
    input logic [RF_W-1:0] rf_idx,
    input logic [IF_W-1:0] if_idx
);
    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (rf_idx == '0 && if_idx == '0)); // R1

    AST_RF_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        rf_idx <= (band_q ? RF_W'(AM_RF_MAX) : RF_W'(FM_RF_MAX))); // R4

    AST_IF_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        if_idx <= (band_q ? IF_W'(AM_IF_MAX) : IF_W'(FM_IF_MAX))); // R6

    AST_IF_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(band_sel) == $past(band_q) && if_idx != $past(if_idx))
        |-> rf_idx == $past(rf_idx)); // R5

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(band_sel) == $past(band_q))
        |-> (rf_idx == $past(rf_idx) || rf_idx == $past(rf_idx) + RF_W'(1)
             || rf_idx + RF_W'(1) == $past(rf_idx))); // R7

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && $past(band_sel) == $past(band_q))
        |-> ($stable(rf_idx) && $stable(if_idx))); // R7

    AST_BAND_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(band_sel) != $past(band_q))
        |-> (rf_idx == '0 && if_idx == '0)); // R8
endmodule

bind agc_step_ctrl agc_step_ctrl_chk #(
    .RF_W(RF_W), .IF_W(IF_W),
    .FM_RF_MAX(FM_RF_MAX), .AM_RF_MAX(AM_RF_MAX),
    .FM_IF_MAX(FM_IF_MAX), .AM_IF_MAX(AM_IF_MAX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .band_sel (band_sel),
    .band_q   (st_q.band),
    .tick     (tick),
    .rf_idx   (rf_idx),
    .if_idx   (if_idx)
);

// File: tb/agc_step_ctrl_test.sv
`timescale 1ns/1ps
module agc_step_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       band_sel = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] level = 8'd0;
    logic [4:0] rf_idx;
    logic [2:0] if_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural reference state
    int m_rf = 0, m_if = 0, m_band = 0;

    always #2.5 clk = ~clk;

    agc_step_ctrl uut (
        .clk(clk), .rst_n(rst_n), .band_sel(band_sel), .tick(tick),
        .level(level), .rf_idx(rf_idx), .if_idx(if_idx)
    );

    task automatic model_update(input int b, input int t, input int lvl);
        int thr_rf, thr_if, max_rf, max_if, e;
        thr_rf = (b == 1) ? 80 : 75;
        thr_if = (b == 1) ? 45 : 40;
        max_rf = (b == 1) ? 21 : 22;
        max_if = (b == 1) ? 5 : 3;
        if (b != m_band) begin
            m_rf = 0; m_if = 0;
        end else if (t != 0) begin
            e = lvl - 3 * m_rf;
            if (m_rf < max_rf && lvl > thr_rf + 3 * m_rf) m_rf++;
            else if (m_rf > 0 && lvl < thr_rf + 3 * (m_rf - 1) - 3) m_rf--;
            else if (m_if < max_if && e > thr_if + 6 * m_if) m_if++;
            else if (m_if > 0 && e < thr_if + 6 * (m_if - 1) - 6) m_if--;
        end
        m_band = b;
    endtask

    task automatic step(input int b, input int t, input int lvl);
        @(negedge clk);
        band_sel = b[0];
        tick     = t[0];
        level    = lvl[7:0];
        model_update(b, t, lvl);
        @(posedge clk);
        #1;
        n_chk++;
        if (rf_idx != m_rf[4:0] || if_idx != m_if[2:0]) begin
            n_bad++;
            $display("FAIL R7 model: rf=%0d if=%0d expected rf=%0d if=%0d",
                     rf_idx, if_idx, m_rf, m_if);
        end
    endtask

    task automatic expect_idx(input int rf_e, input int if_e, input string tag);
        n_chk++;
        if (rf_idx != rf_e[4:0] || if_idx != if_e[2:0]) begin
            n_bad++;
            $display("FAIL %s: rf=%0d if=%0d expected rf=%0d if=%0d",
                     tag, rf_idx, if_idx, rf_e, if_e);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        expect_idx(0, 0, "R1 during reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        expect_idx(0, 0, "R1 after reset");

        // FM RF threshold boundary and IF loop
        step(0, 1, 75); expect_idx(0, 1, "R2 FM at threshold no RF step, R5 IF step");
        step(0, 1, 76); expect_idx(1, 1, "R2 FM above threshold");
        step(0, 1, 73); expect_idx(1, 2, "R3 FM inside hysteresis");
        step(0, 1, 72); expect_idx(1, 3, "R3 FM at lower edge holds");
        step(0, 1, 71); expect_idx(0, 3, "R3 FM below lower edge");
        step(0, 1, 30); expect_idx(0, 2, "R5 IF restores");
        step(0, 1, 30);
        step(0, 1, 30); expect_idx(0, 0, "R5 IF back to full gain");

        // no tick, no movement
        for (int i = 0; i < 5; i++) step(0, 0, 200);
        expect_idx(0, 0, "R7 no tick holds");

        // FM saturation; IF waits for RF
        for (int i = 0; i < 22; i++) step(0, 1, 200);
        expect_idx(22, 0, "R5 IF waits while RF climbs");
        for (int i = 0; i < 18; i++) step(0, 1, 200);
        expect_idx(22, 3, "R4 R6 FM limits");

        // band change during a tick at high level
        step(1, 1, 200); expect_idx(0, 0, "R8 band change resets");
        for (int i = 0; i < 40; i++) step(1, 1, 200);
        expect_idx(21, 5, "R4 R6 AM limits");

        step(0, 1, 200); expect_idx(0, 0, "R8 back to FM");
        step(1, 0, 0);   expect_idx(0, 0, "R8 AM no tick");
        step(1, 1, 80);  expect_idx(0, 1, "R2 AM at threshold no RF step");
        step(1, 1, 81);  expect_idx(1, 1, "R2 AM above threshold");

        // mixed traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int b;
            b = m_band;
            if ($urandom_range(0, 199) == 0) b = 1 - m_band;
            step(b, ($urandom_range(0, 2) != 0) ? 1 : 0,
                 40 + 10 * $sin(i / 60.0) * 0 + $urandom_range(0, 150));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule